// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block models a synchronous, pipelined single-port SRAM of `2**ADDR_W` words of `DATA_W` bits, split into byte lanes. With `ADDR_W = 16` it holds 64K words. The default is `ADDR_W = 10`, which keeps the elaborated array small. Every control input is sampled on the rising clock edge, except the output enable, which acts combinationally.

An access starts when one of two active-low address strobes is accepted. One strobe is meant for a processor and the other for a memory controller. The strobe loads the full address and seeds a 2-bit burst counter from its two low bits. An advance input then steps through the four-word block, in linear or interleaved order as a static strap selects. Writes can cover all lanes at once or single byte lanes. Read data appears one cycle after the edge that addressed it.

The bidirectional data bus is split into three ports: `wdata`, `rdata` and `rdata_vld`. Write data is taken on every edge that carries a write. There is no back-pressure in either direction. The consumer must take `rdata` in every cycle in which `rdata_vld` is high.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected, and `rdata_vld` stays low until an accepted strobe starts an access.
- R2: An accepted strobe while `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 loads the address and starts an access. An accepted strobe under any other select combination deselects the block, and `rdata_vld` is low in the following cycle.
- R3: When both strobes are low on the same edge, only `proc_strb_n` takes effect. An edge on which `proc_strb_n` is accepted performs no write, whatever the write controls hold.
- R4: `proc_strb_n` is ignored while `sel_a_n`=1. A low `ctrl_strb_n` on that same edge is still accepted.
- R5: On an edge with no accepted strobe, `step_n`=0 during an access moves the burst count on by one. With `step_n`=1 and no accepted strobe, the address is held.
- R6: With `order_ilv`=0 the two low address bits follow start+count modulo 4 (for example 1,2,3,0).
- R7: With `order_ilv`=1 the two low address bits follow start XOR count (for example 1,0,3,2).
- R8: `all_wr_n`=0 writes every byte lane of the addressed word, regardless of `lane_wr_en_n` and `lane_sel_n`.
- R9: With `all_wr_n`=1 and `lane_wr_en_n`=0, lane b (bits 8b+7..8b) is written exactly when `lane_sel_n[b]`=0. With `lane_wr_en_n`=1, nothing is written.
- R10: A read edge presents the addressed word on `rdata` in the next cycle. A write edge gives `rdata_vld`=0 in the next cycle.
- R11: `out_en_n`=1 forces `rdata_vld` low combinationally. The first read beat after the block leaves the deselected state is not presented, whatever `out_en_n` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, captured on an accepted strobe |
| proc_strb_n | input | 1 | Processor address strobe, active low, has priority |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Select term, active low; also gates the processor strobe |
| sel_b | input | 1 | Select term, active high |
| sel_c_n | input | 1 | Select term, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_en_n | input | 1 | Byte-lane write enable, active low |
| lane_sel_n | input | DATA_W/8 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| order_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data is presented this cycle |

## Verification
The assertions assume that the burst-order strap does not change while a burst is in progress. They also assume that `out_en_n` changes only between clock edges, so that the state it masks is well defined when sampled. The stimulus sets the strap only before starting a fresh strobe, and drives every input, including `out_en_n`, on the falling edge. Reads target only words that the bench has already written, so that no stored value is undefined.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned BURST_W = 2;

  // Low address bits for a given start and step count.
  function automatic logic [BURST_W-1:0] burst_low(
      input logic [BURST_W-1:0] start,
      input logic [BURST_W-1:0] count,
      input logic               ilv);
    logic [BURST_W-1:0] res;
    if (ilv) res = start ^ count;
    else     res = start + count;
    return res;
  endfunction
endpackage

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              acc_en,
  output logic              proc_load,
  output logic              first_q
);
  logic              p_take, c_take, strobe, chip_sel, load, drop, adv_go;
  logic [ADDR_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q, cnt_nx;
  logic              active_q;

  always_comb begin
    p_take    = !proc_strb_n && !sel_a_n;
    c_take    = !ctrl_strb_n && !p_take;
    strobe    = p_take || c_take;
    chip_sel  = !sel_a_n && sel_b && !sel_c_n;
    load      = strobe && chip_sel;
    drop      = strobe && !chip_sel;
    adv_go    = !strobe && !step_n && active_q;
    cnt_nx    = adv_go ? cnt_q + 1'b1 : cnt_q;
    proc_load = load && p_take;
    acc_en    = load || (active_q && !drop);
    if (load)
      eff_addr = addr;
    else
      eff_addr = {base_q[ADDR_W-1:BURST_W],
                  burst_low(base_q[BURST_W-1:0], cnt_nx, order_ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      first_q <= load && !active_q;
      if (load) begin
        base_q   <= addr;
        cnt_q    <= '0;
        active_q <= 1'b1;
      end else if (drop) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/burst_sram_wmask.sv
module burst_sram_wmask #(
  parameter int unsigned LANES = 4
) (
  input  logic             acc_en,
  input  logic             suppress,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we
);
  always_comb begin
    lane_we = '0;
    if (acc_en && !suppress) begin
      if (!all_wr_n)          lane_we = '1;
      else if (!lane_wr_en_n) lane_we = ~lane_sel_n;
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rword
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (acc_en && lane_we[b])
        store[addr] <= wdata[b*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (acc_en)
        lane_q <= lane_we[b] ? wdata[b*LANE_W +: LANE_W] : store[addr];
    end

    assign rword[b*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [DATA_W/8-1:0] lane_sel_n,
  input  logic              out_en_n,
  input  logic              order_ilv,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = DATA_W / LANE_W;

  logic [ADDR_W-1:0] eff_addr;
  logic              acc_en, proc_load, first_q, rd_q;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rword;

  burst_sram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .step_n(step_n), .order_ilv(order_ilv),
    .eff_addr(eff_addr), .acc_en(acc_en), .proc_load(proc_load),
    .first_q(first_q)
  );

  burst_sram_wmask #(.LANES(LANES)) u_wmask (
    .acc_en(acc_en), .suppress(proc_load), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .lane_we(lane_we)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .addr(eff_addr),
    .lane_we(lane_we), .wdata(wdata), .rword(rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= acc_en && (lane_we == '0);
  end

  assign rdata_vld = rd_q && !first_q && !out_en_n;
  assign rdata     = rdata_vld ? rword : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_strb_n,
  input logic              ctrl_strb_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              step_n,
  input logic              all_wr_n,
  input logic              lane_wr_en_n,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_vld
);
  logic chip_sel;
  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  // R11
  oe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_vld);

  // R2
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((!proc_strb_n && !sel_a_n) || !ctrl_strb_n) && !chip_sel) |=> !rdata_vld);

  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strb_n && (proc_strb_n || sel_a_n) && chip_sel && !all_wr_n)
      |=> !rdata_vld);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_strb_n || sel_a_n) && ctrl_strb_n && step_n && all_wr_n &&
     lane_wr_en_n && rdata_vld)
      |=> (out_en_n || (rdata_vld && $stable(rdata))));
endmodule

bind burst_sram burst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n),
  .ctrl_strb_n(ctrl_strb_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
  .sel_c_n(sel_c_n), .step_n(step_n), .all_wr_n(all_wr_n),
  .lane_wr_en_n(lane_wr_en_n), .out_en_n(out_en_n),
  .rdata(rdata), .rdata_vld(rdata_vld)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        proc_strb_n = 1'b1, ctrl_strb_n = 1'b1;
  logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic        step_n = 1'b1, all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]  lane_sel_n = 4'hF;
  logic        out_en_n = 1'b0, order_ilv = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_vld;

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  logic  q_en [$];
  logic [31:0] q_data [$];
  string q_tag [$];

  logic [31:0] mmem [1024];
  logic        m_act = 1'b0;
  logic [9:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;

  always #10 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .order_ilv(order_ilv),
    .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Driver: predicts the result of the coming edge and queues it.
  task automatic step();
    logic p, c, s, sel, first, pl, en;
    logic [9:0] eff;
    logic [3:0] we;
    logic [31:0] m;
    p = !proc_strb_n && !sel_a_n;
    c = !ctrl_strb_n && !p;
    s = p || c;
    sel = !sel_a_n && sel_b && !sel_c_n;
    first = 1'b0;
    pl = 1'b0;
    if (s && sel) begin
      first = !m_act; m_act = 1'b1; m_base = addr; m_cnt = 2'd0; pl = p;
    end else if (s) begin
      m_act = 1'b0;
    end else if (!step_n && m_act) begin
      m_cnt = m_cnt + 2'd1;
    end
    eff = {m_base[9:2], order_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
    we = 4'h0;
    if (m_act && !pl) we = !all_wr_n ? 4'hF : (!lane_wr_en_n ? ~lane_sel_n : 4'h0);
    m = mmem[eff];
    for (int b = 0; b < 4; b++) if (we[b]) m[b*8 +: 8] = wdata[b*8 +: 8];
    if (m_act) mmem[eff] = m;
    en = m_act && (we == 4'h0) && !first && !out_en_n;
    q_en.push_back(en);
    q_data.push_back(m);
    q_tag.push_back(cur_tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; step_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0; out_en_n = 1'b0;
  endtask

  // Monitor: pops one prediction per edge, samples a quarter period later.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_en.size() != 0) begin
        logic e; logic [31:0] d; string t;
        e = q_en.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
        checks++;
        if (rdata_vld !== e || (e && rdata !== d)) begin
          fails++;
          $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                   t, rdata_vld, rdata, e, d);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: nothing presented after reset
    checks++;
    if (rdata_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: vld=%0b expected 0", rdata_vld);
    end
    cur_tag = "R1"; step();

    // R8: whole-word writes over block 0x10..0x13, linear steps (R6)
    cur_tag = "R8";
    addr = 10'h010; ctrl_strb_n = 1'b0; all_wr_n = 1'b0; wdata = 32'hA0A1A2A3;
    lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
    step();
    ctrl_strb_n = 1'b1; step_n = 1'b0;
    wdata = 32'hB0B1B2B3; step();
    wdata = 32'hC0C1C2C3; step();
    wdata = 32'hD0D1D2D3; step();
    idle_in();

    // R6, R10: linear read burst from 0x11 -> 11,12,13,10
    cur_tag = "R6";
    addr = 10'h011; proc_strb_n = 1'b0; step();
    proc_strb_n = 1'b1; step_n = 1'b0;
    step(); step(); step();
    // R5: hold with no strobe and no advance
    cur_tag = "R5"; step_n = 1'b1; step(); step();

    // R2: deselect with a controller strobe, then restart; R11 first beat masked
    cur_tag = "R2"; ctrl_strb_n = 1'b0; sel_b = 1'b0; step();
    ctrl_strb_n = 1'b1; sel_b = 1'b1; step();
    cur_tag = "R11"; addr = 10'h012; proc_strb_n = 1'b0; step();
    proc_strb_n = 1'b1; step_n = 1'b0; step(); step();
    // R11: output enable high forces nothing presented
    out_en_n = 1'b1; step(); out_en_n = 1'b0; step_n = 1'b1; step();

    // R7: interleaved order from 0x11 -> 11,10,13,12
    cur_tag = "R7"; order_ilv = 1'b1;
    addr = 10'h011; ctrl_strb_n = 1'b0; step();
    ctrl_strb_n = 1'b1; step_n = 1'b0;
    step(); step(); step(); step();
    step_n = 1'b1; order_ilv = 1'b0;

    // R9: lanes 0 and 2 written at 0x12, then read
    cur_tag = "R9";
    addr = 10'h012; ctrl_strb_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = 4'b1010;
    wdata = 32'h11223344; step();
    idle_in(); step();
    // R9: lane enable high means no write even with selects low
    ctrl_strb_n = 1'b0; lane_sel_n = 4'h0; wdata = 32'hFFFFFFFF; step();
    idle_in(); step();
    // R8: whole-word write overrides lane controls
    cur_tag = "R8";
    ctrl_strb_n = 1'b0; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF; all_wr_n = 1'b0;
    wdata = 32'h5566_7788; step();
    idle_in(); step();

    // R3: both strobes low, processor wins and suppresses the write
    cur_tag = "R3";
    addr = 10'h013; proc_strb_n = 1'b0; ctrl_strb_n = 1'b0; all_wr_n = 1'b0;
    wdata = 32'hDEADBEEF; step();
    idle_in(); step();

    // R4: processor strobe ignored while sel_a_n high
    cur_tag = "R4";
    addr = 10'h010; proc_strb_n = 1'b0; sel_a_n = 1'b1; step();
    sel_a_n = 1'b0; proc_strb_n = 1'b1; step();
    // R4: controller strobe still taken, deselects since sel_a_n high
    proc_strb_n = 1'b0; ctrl_strb_n = 1'b0; sel_a_n = 1'b1; step();
    idle_in(); step();
    cur_tag = "R11"; addr = 10'h013; ctrl_strb_n = 1'b0; step();
    idle_in(); step(); step();

    @(posedge clk); #6;
    finish_run();
  end
endmodule